// File: doc/BRIEF.md
# Serial Engine Command Byte Parser

This block sits between a host byte stream and a synchronous serial/GPIO engine. It takes command bytes one at a time over a valid/ready input, works out from each opcode how many operand bytes follow, collects them, and then gives the engine one command strobe carrying the opcode and up to two operand bytes. When the command produces data (a pin read, a bit shift with the read flag, or a byte-shift batch with the read flag), the engine's result bytes go back to the host over a valid/ready output stream. Opcodes it does not recognise are answered with a two-byte error reply. The parser stops accepting input while a command is in the engine or while a reply is being sent, so the host stream sets the order of every operation.

Opcode byte layout: bit 0 means write data, bit 1 selects bit mode, bit 5 requests read-back, bit 6 marks a TMS write, and bit 7 marks a special command. Special commands are matched on the whole byte: 0x80 sets the low pin byte, 0x82 sets the high pin byte, 0x81 reads the low pins, 0x83 reads the high pins and 0x86 sets the clock divisor. A byte-shift command (bits 1, 6 and 7 clear) carries a 16-bit length and then that many data bytes. These are staged in batches of at most 64 bytes. Each staged byte is sent to the engine as its own strobe, and the batch's results are returned before the next batch is accepted.

The state machine has these states. OPC waits for an opcode. ARG0 and ARG1 collect operands. ISSUE strobes the engine and WAIT waits for it. RESP sends one result byte. ERR0 and ERR1 send the error reply. LEN0 and LEN1 collect the byte-shift length. FILL stages a batch. BISSUE and BWAIT run each staged byte through the engine. BOUT returns the batch results. BNEXT moves on to the next batch.

The transitions are:
- OPC goes to ERR0 on an unknown opcode, to ISSUE on a pin read, to LEN0 on a byte shift, and to ARG0 otherwise.
- ARG0 goes to ISSUE when no second operand follows, and to ARG1 otherwise.
- ARG1 goes to ISSUE.
- ISSUE goes to WAIT.
- WAIT goes to RESP or to OPC once the engine is idle.
- RESP goes to OPC.
- ERR0 goes to ERR1, and ERR1 goes to OPC.
- LEN0 goes to LEN1.
- LEN1 goes to OPC on a zero length and to FILL otherwise.
- FILL goes to BISSUE once the batch is staged.
- BISSUE goes to BWAIT.
- BWAIT goes back to BISSUE for the next staged byte, or on the last one to BOUT or BNEXT.
- BOUT goes to BNEXT.
- BNEXT goes to FILL, or to OPC when no bytes remain.

Top module: `sep_cmd_parser`

## Requirements
- R1: A synchronous reset puts the parser in OPC, with in_ready high and out_valid and cmd_valid low. Any partly collected operands are discarded, so the next accepted byte is decoded as an opcode.
- R2: Opcodes 0x80 (low pins) and 0x82 (high pins) take two operand bytes, value first and then direction mask. They give one strobe with cmd_arg0 = value and cmd_arg1 = mask, and no reply.
- R3: Opcode 0x86 takes the divisor low byte and then the high byte. It gives one strobe with cmd_arg0 = low and cmd_arg1 = high, and no reply.
- R4: Opcodes 0x81 and 0x83 take no operands. They give one strobe with both operand fields zero and return exactly one reply byte, equal to eng_rdata.
- R5: A bit-mode opcode (bit 1 set, bits 6 and 7 clear) takes a bit-count byte, followed by a data byte only when bit 0 is set. The strobe carries the count in cmd_arg0 and the data in cmd_arg1, with cmd_arg1 zero when no data byte is sent. One reply byte is returned only when bit 5 is set.
- R6: A TMS opcode (bit 6 set, bit 1 set, bit 7 clear) takes a count byte and a data byte, gives one strobe carrying both, and returns one reply byte only when bit 5 is set.
- R7: An unknown opcode gets the reply 0xFA and then the opcode byte, with no strobe and no operand bytes consumed. Unknown means bit 7 set with a value other than the five special codes, or bit 6 set with bit 1 clear.
- R8: A byte-shift opcode (bits 1, 6 and 7 clear) takes the length low byte first and then that many data bytes. Each data byte gives one strobe with cmd_arg0 = data and cmd_arg1 = 0. A zero length gives no strobe and no reply.
- R9: Byte-shift data is handled in batches of at most 64 bytes. All of a batch's bytes are accepted before its first strobe. When bit 5 is set, the batch's results are returned in order before the next batch's first byte is accepted.
- R10: in_ready is low from a strobe until the engine has finished and the reply has been sent. It is never high while eng_busy is high or out_valid is high.
- R11: cmd_valid lasts one cycle. From the cycle after the strobe, the parser waits while eng_busy is high and takes eng_rdata in the first cycle that eng_busy is low.
- R12: While out_valid is high and out_ready is low, out_valid stays high and out_data does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Host byte available |
| in_data | input | 8 | Host byte |
| in_ready | output | 1 | Parser accepts a byte this cycle |
| out_valid | output | 1 | Reply byte available |
| out_data | output | 8 | Reply byte |
| out_ready | input | 1 | Host takes the reply byte |
| cmd_valid | output | 1 | One-cycle command strobe to the engine |
| cmd_op | output | 8 | Opcode of the strobed command |
| cmd_arg0 | output | 8 | First operand or shift data byte |
| cmd_arg1 | output | 8 | Second operand, or zero |
| eng_busy | input | 1 | Engine still running the last strobe |
| eng_rdata | input | 8 | Engine result, valid when eng_busy is low after a strobe |

## Verification
The assertions take for granted that eng_busy only rises in the cycle after a strobe and stays high until that command is done. They also take for granted that eng_rdata is stable whenever eng_busy is low after a strobe. Without these, the rule that a busy engine blocks input would not hold. The bench's engine model follows this contract: on each strobe it loads eng_rdata and holds eng_busy for a latency of zero to three cycles that changes from strobe to strobe. The host side is driven with idle gaps on the input and a repeating out_ready pattern that stalls replies, so the hold rule on the output is exercised.

// File: rtl/sep_pkg.sv
package sep_pkg;

    localparam int BYTE_W = 8;

    // opcode flag positions
    localparam int F_WR  = 0;
    localparam int F_BIT = 1;
    localparam int F_RD  = 5;
    localparam int F_TMS = 6;
    localparam int F_SPC = 7;

    localparam logic [BYTE_W-1:0] OP_PIN_LO_SET = 8'h80;
    localparam logic [BYTE_W-1:0] OP_PIN_LO_GET = 8'h81;
    localparam logic [BYTE_W-1:0] OP_PIN_HI_SET = 8'h82;
    localparam logic [BYTE_W-1:0] OP_PIN_HI_GET = 8'h83;
    localparam logic [BYTE_W-1:0] OP_CLK_DIV    = 8'h86;
    localparam logic [BYTE_W-1:0] ERR_TAG       = 8'hFA;

    typedef enum logic [2:0] {
        K_TWO,
        K_READ,
        K_BITS,
        K_TMS,
        K_BYTES,
        K_BAD
    } kind_t;

    typedef enum logic [3:0] {
        S_OPC,
        S_ARG0,
        S_ARG1,
        S_ISSUE,
        S_WAIT,
        S_RESP,
        S_ERR0,
        S_ERR1,
        S_LEN0,
        S_LEN1,
        S_FILL,
        S_BISSUE,
        S_BWAIT,
        S_BOUT,
        S_BNEXT
    } state_t;

endpackage

// File: rtl/sep_opcode_decode.sv
module sep_opcode_decode
    import sep_pkg::*;
(
    input  logic [BYTE_W-1:0] op,
    output kind_t             kind,
    output logic              need2,
    output logic              reply
);

    always_comb begin
        kind  = K_BAD;
        need2 = 1'b0;
        reply = 1'b0;
        if (op[F_SPC]) begin
            unique case (op)
                OP_PIN_LO_SET, OP_PIN_HI_SET, OP_CLK_DIV: begin
                    kind  = K_TWO;
                    need2 = 1'b1;
                end
                OP_PIN_LO_GET, OP_PIN_HI_GET: begin
                    kind  = K_READ;
                    reply = 1'b1;
                end
                default: kind = K_BAD;
            endcase
        end else if (op[F_TMS]) begin
            if (op[F_BIT]) begin
                kind  = K_TMS;
                need2 = 1'b1;
                reply = op[F_RD];
            end
        end else if (op[F_BIT]) begin
            kind  = K_BITS;
            need2 = op[F_WR];
            reply = op[F_RD];
        end else begin
            kind  = K_BYTES;
            reply = op[F_RD];
        end
    end

endmodule

// File: rtl/sep_batch_buf.sv
module sep_batch_buf #(
    parameter  int DEPTH = 64,
    parameter  int W     = 8,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/sep_cmd_parser.sv
module sep_cmd_parser
    import sep_pkg::*;
#(
    parameter int BATCH_MAX = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    output logic              in_ready,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_data,
    input  logic              out_ready,
    output logic              cmd_valid,
    output logic [BYTE_W-1:0] cmd_op,
    output logic [BYTE_W-1:0] cmd_arg0,
    output logic [BYTE_W-1:0] cmd_arg1,
    input  logic              eng_busy,
    input  logic [BYTE_W-1:0] eng_rdata
);

    localparam int IDX_W = $clog2(BATCH_MAX);
    localparam int CNT_W = IDX_W + 1;
    localparam int LEN_W = 2 * BYTE_W;

    state_t            state_q, state_d;
    logic [BYTE_W-1:0] op_q, a0_q, a1_q, res_q;
    kind_t             kind_q;
    logic              need2_q, reply_q;
    logic [LEN_W-1:0]  rem_q, rem_after, len_in;
    logic [CNT_W-1:0]  idx_q, batch_n;
    logic              last, in_fire;

    kind_t             dec_kind;
    logic              dec_need2, dec_reply;
    logic              buf_we;
    logic [BYTE_W-1:0] buf_wdata, buf_rdata;

    sep_opcode_decode u_dec (
        .op    (in_data),
        .kind  (dec_kind),
        .need2 (dec_need2),
        .reply (dec_reply)
    );

    sep_batch_buf #(.DEPTH(BATCH_MAX), .W(BYTE_W)) u_buf (
        .clk   (clk),
        .we    (buf_we),
        .waddr (idx_q[IDX_W-1:0]),
        .wdata (buf_wdata),
        .raddr (idx_q[IDX_W-1:0]),
        .rdata (buf_rdata)
    );

    assign batch_n   = (rem_q > LEN_W'(BATCH_MAX)) ? CNT_W'(BATCH_MAX) : rem_q[CNT_W-1:0];
    assign last      = (idx_q == batch_n - CNT_W'(1));
    assign rem_after = rem_q - LEN_W'(batch_n);
    assign len_in    = {in_data, a0_q};
    assign in_fire   = in_valid && in_ready;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_OPC;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_OPC: if (in_fire) begin
                unique case (dec_kind)
                    K_BAD:   state_d = S_ERR0;
                    K_READ:  state_d = S_ISSUE;
                    K_BYTES: state_d = S_LEN0;
                    default: state_d = S_ARG0;
                endcase
            end
            S_ARG0:   if (in_fire) state_d = need2_q ? S_ARG1 : S_ISSUE;
            S_ARG1:   if (in_fire) state_d = S_ISSUE;
            S_ISSUE:  state_d = S_WAIT;
            S_WAIT:   if (!eng_busy) state_d = reply_q ? S_RESP : S_OPC;
            S_RESP:   if (out_ready) state_d = S_OPC;
            S_ERR0:   if (out_ready) state_d = S_ERR1;
            S_ERR1:   if (out_ready) state_d = S_OPC;
            S_LEN0:   if (in_fire) state_d = S_LEN1;
            S_LEN1:   if (in_fire) state_d = (len_in == '0) ? S_OPC : S_FILL;
            S_FILL:   if (in_fire && last) state_d = S_BISSUE;
            S_BISSUE: state_d = S_BWAIT;
            S_BWAIT:  if (!eng_busy) begin
                if (!last)        state_d = S_BISSUE;
                else if (reply_q) state_d = S_BOUT;
                else              state_d = S_BNEXT;
            end
            S_BOUT:   if (out_ready && last) state_d = S_BNEXT;
            S_BNEXT:  state_d = (rem_after == '0) ? S_OPC : S_FILL;
            default:  state_d = S_OPC;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (rst) begin
            op_q    <= '0;
            a0_q    <= '0;
            a1_q    <= '0;
            res_q   <= '0;
            kind_q  <= K_BAD;
            need2_q <= 1'b0;
            reply_q <= 1'b0;
            rem_q   <= '0;
            idx_q   <= '0;
        end else begin
            unique case (state_q)
                S_OPC: if (in_fire) begin
                    op_q    <= in_data;
                    kind_q  <= dec_kind;
                    need2_q <= dec_need2;
                    reply_q <= dec_reply;
                    a0_q    <= '0;
                    a1_q    <= '0;
                end
                S_ARG0, S_LEN0: if (in_fire) a0_q <= in_data;
                S_ARG1: if (in_fire) a1_q <= in_data;
                S_WAIT: if (!eng_busy) res_q <= eng_rdata;
                S_LEN1: if (in_fire) begin
                    rem_q <= len_in;
                    idx_q <= '0;
                end
                S_FILL: if (in_fire) idx_q <= last ? '0 : idx_q + CNT_W'(1);
                S_BWAIT: if (!eng_busy) idx_q <= last ? '0 : idx_q + CNT_W'(1);
                S_BOUT: if (out_ready) idx_q <= last ? '0 : idx_q + CNT_W'(1);
                S_BNEXT: begin
                    rem_q <= rem_after;
                    idx_q <= '0;
                end
                default: ;
            endcase
        end
    end

    // batch buffer write port: staged data, then engine results in place
    always_comb begin
        buf_we    = 1'b0;
        buf_wdata = in_data;
        if (state_q == S_FILL && in_fire) begin
            buf_we = 1'b1;
        end else if (state_q == S_BWAIT && !eng_busy) begin
            buf_we    = 1'b1;
            buf_wdata = eng_rdata;
        end
    end

    // outputs
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        out_data  = '0;
        cmd_valid = 1'b0;
        cmd_op    = op_q;
        cmd_arg0  = a0_q;
        cmd_arg1  = a1_q;
        unique case (state_q)
            S_OPC, S_ARG0, S_ARG1, S_LEN0, S_LEN1, S_FILL: in_ready = 1'b1;
            S_ISSUE: cmd_valid = 1'b1;
            S_BISSUE: begin
                cmd_valid = 1'b1;
                cmd_arg0  = buf_rdata;
                cmd_arg1  = '0;
            end
            S_RESP: begin
                out_valid = 1'b1;
                out_data  = res_q;
            end
            S_ERR0: begin
                out_valid = 1'b1;
                out_data  = ERR_TAG;
            end
            S_ERR1: begin
                out_valid = 1'b1;
                out_data  = op_q;
            end
            S_BOUT: begin
                out_valid = 1'b1;
                out_data  = buf_rdata;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/sep_cmd_parser_chk.sv
module sep_cmd_parser_chk (
    input logic       clk,
    input logic       rst,
    input logic       in_ready,
    input logic       out_valid,
    input logic [7:0] out_data,
    input logic       out_ready,
    input logic       cmd_valid,
    input logic       eng_busy
);

    a_r1_reset_idle: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (in_ready && !out_valid && !cmd_valid));

    a_r10_busy_blocks_input: assert property (@(posedge clk) disable iff (rst)
        eng_busy |-> !in_ready);

    a_r10_reply_blocks_input: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !in_ready);

    a_r11_single_strobe: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> !cmd_valid);

    a_r11_strobe_no_input: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> (!in_ready && !out_valid));

    a_r12_out_hold: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

endmodule

bind sep_cmd_parser sep_cmd_parser_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_ready (out_ready),
    .cmd_valid (cmd_valid),
    .eng_busy  (eng_busy)
);

// File: tb/sep_cmd_parser_tb.sv
module sep_cmd_parser_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic       in_valid, in_ready;
    logic [7:0] in_data;
    logic       out_valid, out_ready;
    logic [7:0] out_data;
    logic       cmd_valid;
    logic [7:0] cmd_op, cmd_arg0, cmd_arg1;
    logic       eng_busy;
    logic [7:0] eng_rdata;

    always #5 clk = ~clk;

    sep_cmd_parser u_dut (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_arg0(cmd_arg0), .cmd_arg1(cmd_arg1),
        .eng_busy(eng_busy), .eng_rdata(eng_rdata)
    );

    int n_checks = 0;
    int n_fail   = 0;
    string cur_req = "R1";
    logic [7:0]  stim[$];
    logic [31:0] exp_q[$];   // {kind, x, y, z}: kind 0 accept, 1 strobe, 2 reply

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] eres(input logic [7:0] op, input logic [7:0] a, input logic [7:0] b);
        return op ^ a ^ {b[3:0], b[7:4]} ^ 8'h3C;
    endfunction

    // engine model: latency 0..3 cycles, result loaded at the strobe edge
    int busy_cnt;
    int lat_seq;
    always @(posedge clk) begin
        if (rst) begin
            busy_cnt  <= 0;
            lat_seq   <= 0;
            eng_rdata <= 8'h00;
        end else if (cmd_valid) begin
            busy_cnt  <= lat_seq % 4;
            lat_seq   <= lat_seq + 1;
            eng_rdata <= eres(cmd_op, cmd_arg0, cmd_arg1);
        end else if (busy_cnt > 0) begin
            busy_cnt <= busy_cnt - 1;
        end
    end
    assign eng_busy = (busy_cnt != 0);

    // host reply back-pressure pattern
    int rcyc = 0;
    initial begin
        out_ready = 1'b1;
        forever begin
            @(posedge clk);
            #1;
            rcyc++;
            out_ready = (rcyc % 5 != 3) && (rcyc % 11 != 7);
        end
    end

    // monitor: one event per cycle, compared to the reference stream
    logic [31:0] ev;
    int nev;
    always @(negedge clk) begin
        if (!rst) begin
            nev = 0;
            ev  = 32'h0;
            if (cmd_valid) begin ev = {8'd1, cmd_op, cmd_arg0, cmd_arg1}; nev++; end
            if (out_valid && out_ready) begin ev = {8'd2, out_data, 16'h0}; nev++; end
            if (in_valid && in_ready) begin ev = {8'd0, in_data, 16'h0}; nev++; end
            if (nev > 1) chk(1'b0, {cur_req, " R10 overlap"}, 32'(nev), 32'd1);
            if (nev == 1) begin
                if (exp_q.size() == 0) chk(1'b0, {cur_req, " unexpected event"}, ev, 32'h0);
                else begin
                    logic [31:0] e;
                    e = exp_q.pop_front();
                    chk(ev == e, cur_req, ev, e);
                end
            end
            if (eng_busy) chk(!in_ready, "R10 busy blocks input", 32'(in_ready), 32'd0);
        end
    end

    task automatic push(input logic [7:0] k, input logic [7:0] x, input logic [7:0] y, input logic [7:0] z);
        exp_q.push_back({k, x, y, z});
    endtask

    // behavioural reference for the current stimulus
    task automatic model();
        int i = 0;
        logic [7:0] op, a, b;
        while (i < stim.size()) begin
            op = stim[i]; i++;
            push(0, op, 0, 0);
            if (op == 8'h80 || op == 8'h82 || op == 8'h86) begin      // R2 R3
                a = stim[i]; b = stim[i+1]; i += 2;
                push(0, a, 0, 0); push(0, b, 0, 0); push(1, op, a, b);
            end else if (op == 8'h81 || op == 8'h83) begin            // R4
                push(1, op, 0, 0); push(2, eres(op, 0, 0), 0, 0);
            end else if (op[7] || (op[6] && !op[1])) begin            // R7
                push(2, 8'hFA, 0, 0); push(2, op, 0, 0);
            end else if (op[1]) begin                                 // R5 R6
                a = stim[i]; i++; push(0, a, 0, 0);
                b = 8'h00;
                if (op[6] || op[0]) begin b = stim[i]; i++; push(0, b, 0, 0); end
                push(1, op, a, b);
                if (op[5]) push(2, eres(op, a, b), 0, 0);
            end else begin                                            // R8 R9
                int len;
                a = stim[i]; b = stim[i+1]; i += 2;
                push(0, a, 0, 0); push(0, b, 0, 0);
                len = int'({b, a});
                for (int s = 0; s < len; s += 64) begin
                    int n;
                    n = (len - s > 64) ? 64 : len - s;
                    for (int j = 0; j < n; j++) push(0, stim[i+j], 0, 0);
                    for (int j = 0; j < n; j++) push(1, op, stim[i+j], 0);
                    if (op[5]) for (int j = 0; j < n; j++) push(2, eres(op, stim[i+j], 0), 0, 0);
                    i += n;
                end
            end
        end
    endtask

    int gap = 0;
    task automatic feed(input logic [7:0] b);
        in_valid = 1'b1;
        in_data  = b;
        while (!in_ready) begin @(posedge clk); #1; end
        @(posedge clk); #1;
        in_valid = 1'b0;
        gap++;
        if (gap % 7 == 0) begin @(posedge clk); #1; end
    endtask

    task automatic drain(input string req);
        int t = 0;
        while (exp_q.size() != 0 && t < 5000) begin @(posedge clk); t++; end
        repeat (3) @(posedge clk);
        #1;
        chk(exp_q.size() == 0, {req, " drained"}, 32'(exp_q.size()), 32'd0);
        chk(in_ready && !out_valid, {req, " idle"}, {30'd0, in_ready, out_valid}, 32'd2);
    endtask

    task automatic play(input string req);
        cur_req = req;
        model();
        foreach (stim[k]) feed(stim[k]);
        drain(req);
        stim.delete();
    endtask

    task automatic do_reset();
        rst = 1'b1;
        in_valid = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        rst = 1'b0;
    endtask

    initial begin
        rst = 1'b1; in_valid = 1'b0; in_data = 8'h00;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        // R1: reset state
        chk(in_ready == 1'b1, "R1 in_ready", 32'(in_ready), 32'd1);
        chk(out_valid == 1'b0, "R1 out_valid", 32'(out_valid), 32'd0);
        chk(cmd_valid == 1'b0, "R1 cmd_valid", 32'(cmd_valid), 32'd0);

        // R2 R3 R4 R11: pin set, divisor, pin reads
        stim = '{8'h80, 8'hA5, 8'h3C, 8'h82, 8'h01, 8'hFF, 8'h86, 8'h34, 8'h12, 8'h81, 8'h83};
        play("R2_R3_R4");

        // R5 R6: bit-mode and TMS variants
        stim = '{8'h22, 8'h07, 8'h23, 8'h05, 8'hC3, 8'h02, 8'h03, 8'h03, 8'h01, 8'h99,
                 8'h4B, 8'h02, 8'h81, 8'h6B, 8'h06, 8'h55, 8'h6A, 8'h04, 8'h0F};
        play("R5_R6");

        // R7: unknown opcodes, then normal parsing continues
        stim = '{8'hAA, 8'h48, 8'hFA, 8'h80, 8'h11, 8'h22, 8'hC0, 8'h84};
        play("R7");

        // R8: short byte shifts, with and without read, and zero length
        stim = '{8'h31, 8'h03, 8'h00, 8'h10, 8'h20, 8'h30,
                 8'h11, 8'h05, 8'h00, 8'hA1, 8'hB2, 8'hC3, 8'hD4, 8'hE5,
                 8'h30, 8'h00, 8'h00, 8'h83};
        play("R8");

        // R9: 130 bytes (64+64+2) with read, then exactly 64 bytes
        stim = '{8'h31, 8'h82, 8'h00};
        for (int k = 0; k < 130; k++) stim.push_back(8'(k * 7 + 1));
        stim.push_back(8'h39); stim.push_back(8'h40); stim.push_back(8'h00);
        for (int k = 0; k < 64; k++) stim.push_back(8'(k * 13 + 5));
        play("R9");

        // R9: 70 bytes without read (64+6)
        stim = '{8'h10, 8'h46, 8'h00};
        for (int k = 0; k < 70; k++) stim.push_back(8'(k + 100));
        play("R9_noread");

        // R1: reset mid-command discards partial operands
        cur_req = "R1_partial";
        push(0, 8'h80, 0, 0); push(0, 8'h11, 0, 0);
        feed(8'h80); feed(8'h11);
        @(posedge clk); #1;
        chk(exp_q.size() == 0, "R1 partial accepted", 32'(exp_q.size()), 32'd0);
        do_reset();
        chk(in_ready && !out_valid && !cmd_valid, "R1 after reset", {29'd0, in_ready, out_valid, cmd_valid}, 32'd4);
        stim = '{8'h82, 8'h5A, 8'h0F};
        play("R1_reopcode");

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired in %s", cur_req);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule